// File: doc/BRIEF.md
# Multi-Lane I2S Master Transmitter

This block turns PCM audio into standard I2S serial streams on up to four parallel data lanes that share one bit clock and one word-select clock. The block is the bus master: it divides its own clock by a programmable integer to make the bit clock (SCK) and derives the word-select clock (LRCLK) from the bit count. Each stereo frame is 64 SCK periods long, with 32 bit slots for the left channel and 32 for the right.

Audio arrives one whole frame per stream beat. Each beat carries up to eight channel samples side by side. A small FIFO holds these frames until the serializer needs them. At every frame boundary the serializer takes one frame from the FIFO. Channel 2k goes out on lane k in the left half, and channel 2k+1 goes out on lane k in the right half.

Lanes above the configured channel count stay low. If the FIFO is empty at a frame boundary, the block sends a silent frame and sets a sticky underflow flag, which can raise an interrupt. The configuration is applied while the block is disabled, and it is held steady while the block runs.

Top module: `i2s_multilane_tx`

## Requirements
- R1: While `cfg_enable` is high, SCK is a square wave with each half period equal to `cfg_div`+1 clock cycles, so consecutive rising edges are 2*(`cfg_div`+1) cycles apart. SCK starts low when the block is enabled.
- R2: The first falling SCK edge after enabling starts bit position 0 of a frame. Each later falling edge advances the position modulo 64. LRCLK is low (left) for positions 0 to 31 and high (right) for positions 32 to 63. Before the first falling edge, LRCLK and all lanes are low.
- R3: In each 32-bit half frame, position 0 and every position after the sample's last bit are driven as zero. A sample occupies positions 1 to W, MSB first. W is 24 when `cfg_width24`=1, using all 24 bits of the channel field, and 16 when `cfg_width24`=0, using the low 16 bits of the field.
- R4: Channel c occupies bits [24c+23:24c] of `s_tdata`. Channel 2k is sent on `sdata[k]` while LRCLK is low, and channel 2k+1 is sent on `sdata[k]` while LRCLK is high.
- R5: Lane k drives zero for the whole frame unless `cfg_channels` is greater than 2k. For example, lane 1 is active only above 2 channels, and lane 3 only above 6 channels.
- R6: Serial data and LRCLK change only together with a falling SCK edge, or when the block is disabled.
- R7: Frames are sent in the order they were accepted, one per frame boundary. `s_tready` is low exactly when FIFO_DEPTH frames are stored, and a beat is accepted when `s_tvalid` and `s_tready` are both high.
- R8: If the FIFO is empty at a frame boundary, an all-zero frame is sent and a sticky underflow flag is set. `irq` equals the flag AND `cfg_irq_en`. A pulse on `irq_clr` clears the flag, except when a new underflow occurs in the same cycle, in which case the flag stays set.
- R9: While `cfg_enable` is low, SCK, LRCLK and all lanes are held low, and the divider and bit position restart from their initial state. The FIFO contents and the underflow flag are kept.
- R10: After reset, SCK, LRCLK, all lanes and `irq` are low, and the FIFO is empty with `s_tready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Audio master clock; all logic runs on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| s_tdata | input | 2*LANES*DW | One frame: channel c in bits [DW*c+DW-1:DW*c] |
| s_tvalid | input | 1 | Frame beat valid |
| s_tready | output | 1 | FIFO has room for a frame |
| cfg_enable | input | 1 | Run the clocks and serializer |
| cfg_width24 | input | 1 | 1: 24-bit samples, 0: 16-bit samples |
| cfg_channels | input | $clog2(2*LANES+1) | Number of audio channels in use |
| cfg_div | input | DIV_W | SCK half period minus one, in clock cycles |
| cfg_irq_en | input | 1 | Let the underflow flag drive `irq` |
| irq_clr | input | 1 | Clear the sticky underflow flag |
| sck | output | 1 | Bit clock |
| lrclk | output | 1 | Word-select clock, low for left |
| sdata | output | LANES | Serial data lanes |
| irq | output | 1 | Active-high underflow interrupt |

## Verification
The assertions check on every cycle that a disabled block keeps its clocks and lanes low. They also check that lane data and LRCLK move only with a falling SCK edge, that an interrupt can only rise at a frame boundary, that the FIFO count never exceeds its depth, and that the top lane stays silent under a low channel count.

The bench scenarios are what show the actual bit stream. They cover both sample widths, every even channel count from two to eight, and three divider ratios, and they rebuild the expected bit from arithmetic sample values at each SCK rising edge. The SCK period, the channel-to-lane mapping, zero padding, frame order, the silent frame on underflow, interrupt masking and the full FIFO are all checked this way.

// File: rtl/i2s_mltx_pkg.sv
// Shared constants for the multi-lane I2S transmitter.
// Assumes a fixed 32-bit slot per channel, which gives a 64-bit stereo frame.
package i2s_mltx_pkg;
    localparam int SLOT_BITS = 32;
    localparam int IDX_W     = $clog2(2 * SLOT_BITS);
    localparam int SHORT_DW  = 16;
endpackage

// File: rtl/i2s_tx_clkgen.sv
// SCK / LRCLK generator. It divides clk by 2*(div+1) to make SCK and counts
// falling SCK edges modulo 64 to give the bit position in the frame.
// Assumes div is held steady while en is high.
module i2s_tx_clkgen
    import i2s_mltx_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             sck,
    output logic             lrclk,
    output logic             fall_evt,
    output logic [IDX_W-1:0] next_idx
);
    logic [DIV_W-1:0] cnt;
    logic [IDX_W-1:0] idx;

    assign next_idx = idx + IDX_W'(1);
    assign fall_evt = en && sck && (cnt == div);

    // Divider, SCK toggle, and bit position advanced on each falling SCK edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt   <= '0;
            sck   <= 1'b0;
            idx   <= '1;
            lrclk <= 1'b0;
        end else if (cnt == div) begin
            cnt <= '0;
            sck <= ~sck;
            if (sck) begin
                idx   <= next_idx;
                lrclk <= next_idx[IDX_W-1];
            end
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/i2s_tx_fifo.sv
// Synchronous frame FIFO. Assumes DEPTH is a power of two.
// A push when full and a pop when empty are both ignored.
module i2s_tx_fifo #(
    parameter int W     = 192,
    parameter int DEPTH = 4,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] count
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          push_ok, pop_ok;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = mem[rp];

    // Storage write.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= din;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push_ok) wp <= wp + AW'(1);
            if (pop_ok)  rp <= rp + AW'(1);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/i2s_tx_lanes.sv
// Per-lane serializer. It picks the left or right sample of its lane from the
// current frame and registers one bit on every falling SCK edge.
// Assumes a position 0 delay slot and zero padding after the sample.
module i2s_tx_lanes
    import i2s_mltx_pkg::*;
#(
    parameter int LANES = 4,
    parameter int DW    = 24,
    parameter int CH_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    fall_evt,
    input  logic [IDX_W-1:0]        next_idx,
    input  logic [2*LANES*DW-1:0]   frame,
    input  logic                    width24,
    input  logic [CH_W-1:0]         channels,
    output logic [LANES-1:0]        sdata
);
    logic [IDX_W-2:0] pos;
    int               wlen;

    assign pos  = next_idx[IDX_W-2:0];
    assign wlen = width24 ? DW : SHORT_DW;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [DW-1:0] smp, sh;
        logic          on, bit_v, lane_q;

        assign on = (int'(channels) > 2 * k);

        // Select the sample of the current half and extract the bit for this position.
        always_comb begin
            smp   = next_idx[IDX_W-1] ? frame[(2*k+1)*DW +: DW] : frame[(2*k)*DW +: DW];
            sh    = '0;
            bit_v = 1'b0;
            if (on && (pos != '0) && (int'(pos) <= wlen)) begin
                sh    = smp >> (wlen - int'(pos));
                bit_v = sh[0];
            end
        end

        // Lane output register, updated only on a falling SCK edge.
        always_ff @(posedge clk) begin
            if (!rst_n || !en) lane_q <= 1'b0;
            else if (fall_evt) lane_q <= bit_v;
        end

        assign sdata[k] = lane_q;
    end
endmodule

// File: rtl/i2s_multilane_tx.sv
// Multi-lane I2S master transmitter top. Frames enter a FIFO from the stream
// input. At each frame boundary one frame is latched, or zeros are used and
// the underflow flag is set, and the frame is serialized on all lanes.
// Assumes the cfg_* inputs change only while cfg_enable is low.
module i2s_multilane_tx
    import i2s_mltx_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int DW         = 24,
    parameter int FIFO_DEPTH = 4,
    parameter int DIV_W      = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [2*LANES*DW-1:0]             s_tdata,
    input  logic                              s_tvalid,
    output logic                              s_tready,
    input  logic                              cfg_enable,
    input  logic                              cfg_width24,
    input  logic [$clog2(2*LANES+1)-1:0]      cfg_channels,
    input  logic [DIV_W-1:0]                  cfg_div,
    input  logic                              cfg_irq_en,
    input  logic                              irq_clr,
    output logic                              sck,
    output logic                              lrclk,
    output logic [LANES-1:0]                  sdata,
    output logic                              irq
);
    localparam int NCH     = 2 * LANES;
    localparam int FRAME_W = NCH * DW;
    localparam int CH_W    = $clog2(NCH + 1);
    localparam int CNT_W   = $clog2(FIFO_DEPTH + 1);

    logic               fall_evt, frame_start, fifo_empty, fifo_full, uflow;
    logic [IDX_W-1:0]   next_idx;
    logic [FRAME_W-1:0] fifo_dout, cur_frame;
    logic [CNT_W-1:0]   fifo_cnt;

    assign frame_start = fall_evt && (next_idx == '0);
    assign s_tready    = !fifo_full;
    assign irq         = uflow && cfg_irq_en;

    i2s_tx_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .en(cfg_enable), .div(cfg_div),
        .sck(sck), .lrclk(lrclk), .fall_evt(fall_evt), .next_idx(next_idx)
    );

    i2s_tx_fifo #(.W(FRAME_W), .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(s_tvalid), .din(s_tdata),
        .pop(frame_start), .dout(fifo_dout), .empty(fifo_empty),
        .full(fifo_full), .count(fifo_cnt)
    );

    // Latch the next frame at a boundary; an empty FIFO gives a silent frame.
    always_ff @(posedge clk) begin
        if (!rst_n) cur_frame <= '0;
        else if (frame_start) cur_frame <= fifo_empty ? '0 : fifo_dout;
    end

    // Sticky underflow flag: a new underflow takes priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) uflow <= 1'b0;
        else if (frame_start && fifo_empty) uflow <= 1'b1;
        else if (irq_clr) uflow <= 1'b0;
    end

    i2s_tx_lanes #(.LANES(LANES), .DW(DW), .CH_W(CH_W)) u_lanes (
        .clk(clk), .rst_n(rst_n), .en(cfg_enable), .fall_evt(fall_evt),
        .next_idx(next_idx), .frame(cur_frame), .width24(cfg_width24),
        .channels(cfg_channels), .sdata(sdata)
    );
endmodule

// File: rtl/i2s_multilane_tx_chk.sv
// Assertion checker for i2s_multilane_tx. It is attached with bind and
// observes only ports plus the FIFO occupancy.
module i2s_multilane_tx_chk #(
    parameter int LANES      = 4,
    parameter int FIFO_DEPTH = 4,
    parameter int CNT_W      = 3
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cfg_enable,
    input logic                         cfg_irq_en,
    input logic [$clog2(2*LANES+1)-1:0] cfg_channels,
    input logic [CNT_W-1:0]             fifo_cnt,
    input logic                         sck,
    input logic                         lrclk,
    input logic [LANES-1:0]             sdata,
    input logic                         irq
);
    p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> (!sck && !lrclk && sdata == '0));

    p_sck_needs_enable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |-> $past(cfg_enable));

    p_data_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdata) |-> ($fell(sck) || !$past(cfg_enable)));

    p_lr_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lrclk) |-> ($fell(sck) || !$past(cfg_enable)));

    p_irq_at_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq) && $past(cfg_irq_en)) |-> $fell(sck));

    p_fifo_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fifo_cnt) <= FIFO_DEPTH);

    p_top_lane_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && $past(cfg_enable) && $stable(cfg_channels)
         && int'(cfg_channels) <= 2 * (LANES - 1)) |-> !sdata[LANES-1]);
endmodule

bind i2s_multilane_tx i2s_multilane_tx_chk #(
    .LANES(LANES), .FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/sim_i2s_multilane_tx.sv
// Sweep bench for i2s_multilane_tx. It covers both widths, channel counts
// 2/4/6/8 and dividers 0..2. Each SCK rise is checked against a bit computed
// from arithmetic sample values.
module sim_i2s_multilane_tx;
    timeunit 1ns; timeprecision 1ps;

    localparam int LANES = 4, DW = 24, DEPTH = 4, DIV_W = 8;
    localparam int NCH = 2 * LANES, FW = NCH * DW;

    logic             clk = 1'b0, rst_n = 1'b0;
    logic [FW-1:0]    s_tdata = '0;
    logic             s_tvalid = 1'b0, s_tready;
    logic             cfg_enable = 1'b0, cfg_width24 = 1'b0, cfg_irq_en = 1'b0, irq_clr = 1'b0;
    logic [3:0]       cfg_channels = 4'd2;
    logic [DIV_W-1:0] cfg_div = '0;
    logic             sck, lrclk, irq;
    logic [LANES-1:0] sdata;

    int n_chk = 0, n_err = 0, cyc = 0;
    bit done = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    i2s_multilane_tx #(.LANES(LANES), .DW(DW), .FIFO_DEPTH(DEPTH), .DIV_W(DIV_W)) u0 (
        .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
        .s_tready(s_tready), .cfg_enable(cfg_enable), .cfg_width24(cfg_width24),
        .cfg_channels(cfg_channels), .cfg_div(cfg_div), .cfg_irq_en(cfg_irq_en),
        .irq_clr(irq_clr), .sck(sck), .lrclk(lrclk), .sdata(sdata), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [23:0] smp(input int id, input int fr, input int ch);
        int v;
        v = id * 40503 + fr * 7919 + ch * 104729 + 12345;
        v = v ^ (v << 7) ^ ((ch + 1) << (fr + 9));
        return v[23:0];
    endfunction

    task automatic push_frame(input int id, input int fr);
        @(negedge clk);
        for (int c = 0; c < NCH; c++) s_tdata[c*DW +: DW] = smp(id, fr, c);
        s_tvalid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        s_tvalid = 1'b0;
    endtask

    task automatic run_config(input int id, input bit w24, input int chs, input int dv,
                              input bit ien, input int nfr);
        int rises, since, p, f, q, h, c, wl, expb;
        bit prev, on;
        @(negedge clk);
        cfg_enable = 1'b0; cfg_width24 = w24; cfg_channels = 4'(chs);
        cfg_div = DIV_W'(dv); cfg_irq_en = ien; irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        chk(irq == 1'b0, "R8 irq_clr clears flag", int'(irq), 0);
        for (int fr = 0; fr < nfr; fr++) push_frame(id, fr);
        if (nfr == DEPTH) chk(s_tready == 1'b0, "R7 ready low when full", int'(s_tready), 0);
        @(negedge clk);
        cfg_enable = 1'b1;
        rises = 0; since = 0; prev = 1'b0;
        wl = w24 ? 24 : 16;
        while (rises < 1 + (nfr + 1) * 64) begin
            @(negedge clk);
            since++;
            if (sck && !prev) begin
                if (rises >= 1) chk(since == 2 * (dv + 1), "R1 SCK period", since, 2 * (dv + 1));
                since = 0;
                if (rises == 0) begin
                    chk(lrclk == 1'b0 && sdata == '0, "R2 quiet before first fall",
                        int'({lrclk, sdata}), 0);
                end else begin
                    p = (rises - 1) % 64; f = (rises - 1) / 64;
                    h = p / 32; q = p % 32;
                    chk(lrclk == h[0], "R2 LRCLK half", int'(lrclk), h);
                    if (f == nfr - 1 && p == 63)
                        chk(irq == 1'b0, "R8 no flag before underflow", int'(irq), 0);
                    if (f == nfr && p == 0)
                        chk(irq == ien, "R8 underflow irq gated by enable", int'(irq), int'(ien));
                    for (int k = 0; k < LANES; k++) begin
                        c = 2 * k + h;
                        on = (chs > 2 * k);
                        expb = 0;
                        if (on && f < nfr && q >= 1 && q <= wl) expb = int'(smp(id, f, c)[wl - q]);
                        if (!on)
                            chk(sdata[k] == expb[0], "R5 inactive lane", int'(sdata[k]), expb);
                        else if (f >= nfr)
                            chk(sdata[k] == expb[0], "R8 silent frame", int'(sdata[k]), expb);
                        else if (q >= 1 && q <= wl)
                            chk(sdata[k] == expb[0], "R4 lane sample bit", int'(sdata[k]), expb);
                        else
                            chk(sdata[k] == expb[0], "R3 delay or padding bit", int'(sdata[k]), expb);
                    end
                end
                rises++;
            end
            prev = sck;
        end
        @(negedge clk);
        cfg_enable = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(!sck && !lrclk && sdata == '0, "R9 outputs low when disabled",
            int'({sck, lrclk, sdata}), 0);
        chk(irq == ien, "R8 flag sticky while disabled", int'(irq), int'(ien));
        chk(s_tready == 1'b1, "R7 FIFO drained in order", int'(s_tready), 1);
    endtask

    initial begin
        int id;
        repeat (3) @(negedge clk);
        chk(!sck && !lrclk && sdata == '0 && !irq, "R10 outputs low in reset",
            int'({sck, lrclk, sdata, irq}), 0);
        chk(s_tready == 1'b1, "R10 FIFO empty in reset", int'(s_tready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!sck && !lrclk && sdata == '0 && !irq, "R10 outputs low after reset",
            int'({sck, lrclk, sdata, irq}), 0);
        id = 0;
        for (int w = 0; w < 2; w++)
            for (int cn = 1; cn <= 4; cn++)
                for (int d = 0; d < 3; d++) begin
                    run_config(id, w[0], 2 * cn, d, id[0], (d == 2) ? DEPTH : 3);
                    id++;
                end
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        while (!done && cyc < 150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule